// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Two Output Lines

This block collects thirty-two level-sensitive interrupt requests and presents them to a processor on two interrupt lines. Software controls it through a small register window on a simple strobe bus. Each write carries a byte offset and a data word. Reads are combinational and return data in the same cycle.

Software never writes the enable mask directly. It has one register that sets enable bits and another that clears them, so one driver can change a single source without a read-modify-write race. The top bit of the enable mask has two jobs. It enables source 31, and it also gates both outputs. A type word sends each source to line 0 or line 1.

For line 0, the block also gives the index of the lowest-numbered pending source and a valid flag. When the flag is low, the handler knows the interrupt was spurious. Both interrupt lines are registered.

Top module: `irqc_top`

## Requirements
- R1: After reset, the enable mask and the type word are zero. Both interrupt lines are low, the index valid flag is low, and every register reads zero while all inputs are low.
- R2: A write to offset 0x34 sets each enable bit whose data bit is 1. Bits written as 0 keep their value.
- R3: A write to offset 0x38 clears each enable bit whose data bit is 1. Writing all ones clears the whole mask.
- R4: While enable bit 31 is 0, both status words are zero and neither interrupt line goes high.
- R5: A write to offset 0x20 loads the type word. Status word 0 (read at offset 0x00) is raw AND enable AND NOT type. Status word 1 (read at offset 0x04) is raw AND enable AND type. Both are gated by enable bit 31.
- R6: Offset 0x30 reads the source inputs with no mask applied.
- R7: Sources are level-sensitive. A source is pending in its status word for exactly as long as its input is high, with no latching.
- R8: Line 0 is the OR of status word 0, and line 1 is the OR of status word 1. Each line is registered, so it shows the status present at the previous rising clock edge.
- R9: The 5-bit index output gives the lowest-numbered set bit of status word 0. The valid flag is 1 exactly when status word 0 is nonzero.
- R10: Offsets 0x34 and 0x38 both read back the current enable mask. Any offset other than 0x00, 0x04, 0x20, 0x30, 0x34 and 0x38 reads zero.
- R11: Writes to offsets 0x00, 0x04 and 0x30, or to any unmapped offset, change neither the enable mask nor the type word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt requests |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq0_o | output | 1 | Registered interrupt line 0 |
| irq1_o | output | 1 | Registered interrupt line 1 |
| idx_o | output | 5 | Lowest pending source on line 0 |
| idx_vld_o | output | 1 | Status word 0 is nonzero |

## Verification
A wrong enable or type bit appears in the same cycle on the status reads and on the index output. It reaches the interrupt lines one clock edge later. The bench therefore reads back both enable registers, the type word and both status words after every random operation, and it checks the lines one cycle after the change. A set or clear bit that went to the wrong position, or a write decoded at the wrong offset, would show up on the next readback. Corner cases aim at the double role of bit 31 and at writes of all ones and all zeros.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT0,
    SEL_STAT1,
    SEL_TYPE,
    SEL_RAW,
    SEL_ESET,
    SEL_ECLR
  } reg_sel_e;

  localparam logic [7:0] OFS_STAT0 = 8'h00;
  localparam logic [7:0] OFS_STAT1 = 8'h04;
  localparam logic [7:0] OFS_TYPE  = 8'h20;
  localparam logic [7:0] OFS_RAW   = 8'h30;
  localparam logic [7:0] OFS_ESET  = 8'h34;
  localparam logic [7:0] OFS_ECLR  = 8'h38;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_STAT0: decode_ofs = SEL_STAT0;
      OFS_STAT1: decode_ofs = SEL_STAT1;
      OFS_TYPE:  decode_ofs = SEL_TYPE;
      OFS_RAW:   decode_ofs = SEL_RAW;
      OFS_ESET:  decode_ofs = SEL_ESET;
      OFS_ECLR:  decode_ofs = SEL_ECLR;
      default:   decode_ofs = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output reg_sel_e          sel,
  output logic [N_SRC-1:0]  en_q,
  output logic [N_SRC-1:0]  type_q
);
  logic [N_SRC-1:0] en_d;
  logic [N_SRC-1:0] type_d;
  logic             en_ce;
  logic             type_ce;

  assign sel = decode_ofs(bus_addr[7:0]);

  always_comb begin
    en_d    = en_q;
    type_d  = type_q;
    en_ce   = 1'b0;
    type_ce = 1'b0;
    if (bus_we) begin
      case (sel)
        SEL_ESET: begin
          en_d  = en_q | bus_wdata;
          en_ce = 1'b1;
        end
        SEL_ECLR: begin
          en_d  = en_q & ~bus_wdata;
          en_ce = 1'b1;
        end
        SEL_TYPE: begin
          type_d  = bus_wdata;
          type_ce = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      type_q <= '0;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (type_ce) type_q <= type_d;
    end
  end
endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
  parameter int unsigned N_SRC = 32
) (
  input  logic [N_SRC-1:0] src,
  input  logic [N_SRC-1:0] en,
  input  logic [N_SRC-1:0] ty,
  output logic [N_SRC-1:0] stat0,
  output logic [N_SRC-1:0] stat1
);
  localparam int unsigned GATE_BIT = N_SRC - 1;

  logic [N_SRC-1:0] live;

  always_comb begin
    live  = en[GATE_BIT] ? (src & en) : '0;
    stat0 = live & ~ty;
    stat1 = live & ty;
  end
endmodule

// File: rtl/irqc_lowidx.sv
module irqc_lowidx #(
  parameter int unsigned N = 32,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             vld
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    vld = |vec;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic              irq0_o,
  output logic              irq1_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              idx_vld_o
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  reg_sel_e         sel;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] type_q;
  logic [N_SRC-1:0] stat0_w;
  logic [N_SRC-1:0] stat1_w;
  logic             irq0_d;
  logic             irq1_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  irqc_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sel(sel), .en_q(en_q), .type_q(type_q)
  );

  irqc_route #(.N_SRC(N_SRC)) u_route (
    .src(src_i), .en(en_q), .ty(type_q), .stat0(stat0_w), .stat1(stat1_w)
  );

  irqc_lowidx #(.N(N_SRC)) u_idx (
    .vec(stat0_w), .idx(idx_o), .vld(idx_vld_o)
  );

  always_comb begin
    case (sel)
      SEL_STAT0:          bus_rdata = stat0_w;
      SEL_STAT1:          bus_rdata = stat1_w;
      SEL_TYPE:           bus_rdata = type_q;
      SEL_RAW:            bus_rdata = src_i;
      SEL_ESET, SEL_ECLR: bus_rdata = en_q;
      default:            bus_rdata = '0;
    endcase
  end

  always_comb begin
    irq0_d = |stat0_w;
    irq1_d = |stat1_w;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq0_o <= 1'b0;
      irq1_o <= 1'b0;
    end else begin
      irq0_o <= irq0_d;
      irq1_o <= irq1_d;
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N_SRC-1:0]  bus_wdata,
  input logic              irq0_o,
  input logic              irq1_o,
  input logic [IDX_W-1:0]  idx_o,
  input logic              idx_vld_o,
  input logic [N_SRC-1:0]  en_q,
  input logic [N_SRC-1:0]  type_q,
  input logic [N_SRC-1:0]  stat0_w,
  input logic [N_SRC-1:0]  stat1_w
);
  logic wr_set, wr_clr, wr_type;
  assign wr_set  = bus_we && (bus_addr[7:0] == OFS_ESET);
  assign wr_clr  = bus_we && (bus_addr[7:0] == OFS_ECLR);
  assign wr_type = bus_we && (bus_addr[7:0] == OFS_TYPE);

  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_q & $past(bus_wdata)) == '0));

  p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[N_SRC-1] |=> (!irq0_o && !irq1_o));

  p_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat0_w & stat1_w) == '0));

  p_line0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq0_o == $past(|stat0_w)));

  p_line1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq1_o == $past(|stat1_w)));

  p_idx_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_vld_o |-> (stat0_w[idx_o] && ((stat0_w & ~({N_SRC{1'b1}} << idx_o)) == '0)));

  p_idx_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_vld_o |-> (stat0_w == '0));

  p_en_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(en_q));

  p_type_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_type |=> $stable(type_q));
endmodule

bind irqc_top irqc_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq0_o(irq0_o), .irq1_o(irq1_o), .idx_o(idx_o),
  .idx_vld_o(idx_vld_o), .en_q(en_q), .type_q(type_q), .stat0_w(stat0_w),
  .stat1_w(stat1_w)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] src_i;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq0_o, irq1_o, idx_vld_o;
  logic [4:0]  idx_o;

  int          nchk = 0;
  int          nerr = 0;
  logic [31:0] m_en, m_ty;

  irqc_top u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq0_o(irq0_o), .irq1_o(irq1_o), .idx_o(idx_o), .idx_vld_o(idx_vld_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] f_s0(logic [31:0] s, logic [31:0] e, logic [31:0] t);
    return e[31] ? (s & e & ~t) : 32'h0;
  endfunction
  function automatic logic [31:0] f_s1(logic [31:0] s, logic [31:0] e, logic [31:0] t);
    return e[31] ? (s & e & t) : 32'h0;
  endfunction
  function automatic logic [4:0] f_low(logic [31:0] v);
    logic [4:0] r = 5'd0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = 5'(i);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [31:0] s);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; src_i = s;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      8'h34: m_en = m_en | d;
      8'h38: m_en = m_en & ~d;
      8'h20: m_ty = d;
      default: ;
    endcase
  endtask

  task automatic check_all();
    logic [31:0] d, e0, e1;
    e0 = f_s0(src_i, m_en, m_ty);
    e1 = f_s1(src_i, m_en, m_ty);
    @(negedge clk);
    chk("R8 line0", {31'h0, irq0_o}, {31'h0, |e0});
    chk("R8 line1 R4", {31'h0, irq1_o}, {31'h0, |e1});
    chk("R9 valid", {31'h0, idx_vld_o}, {31'h0, |e0});
    if (|e0) chk("R9 index", {27'h0, idx_o}, {27'h0, f_low(e0)});
    rd(8'h00, d); chk("R5 R7 status0", d, e0);
    rd(8'h04, d); chk("R5 status1", d, e1);
    rd(8'h20, d); chk("R5 type", d, m_ty);
    rd(8'h30, d); chk("R6 raw", d, src_i);
    rd(8'h34, d); chk("R2 R10 set readback", d, m_en);
    rd(8'h38, d); chk("R3 R10 clear readback", d, m_en);
    rd(8'h3C, d); chk("R10 unmapped", d, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  ofs [8];
    void'($urandom(32'd1234));
    ofs = '{8'h00, 8'h04, 8'h20, 8'h30, 8'h34, 8'h38, 8'h10, 8'h3C};
    rst_n = 1'b0; src_i = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_en = '0; m_ty = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state
    chk("R1 line0", {31'h0, irq0_o}, 32'h0);
    chk("R1 line1", {31'h0, irq1_o}, 32'h0);
    chk("R1 valid", {31'h0, idx_vld_o}, 32'h0);
    rd(8'h34, d); chk("R1 enable", d, 32'h0);
    rd(8'h20, d); chk("R1 type", d, 32'h0);

    // R4: sources enabled but global gate off
    wr(8'h34, 32'h0000_00F0, 32'hFFFF_FFFF); check_all();
    // R4: gate on, source 31 itself pending on line 0
    wr(8'h34, 32'h8000_0000, 32'h8000_0000); check_all();
    // R5: route to line 1
    wr(8'h20, 32'hFFFF_FFFF, 32'h8000_0010); check_all();
    wr(8'h20, 32'h0000_0000, 32'h0000_0060); check_all();
    // R2: writing zeros to set changes nothing
    wr(8'h34, 32'h0, 32'h0000_0060); check_all();
    // R11: writes to status, raw and unmapped offsets have no effect
    wr(8'h00, 32'hFFFF_FFFF, 32'h0000_0060); check_all();
    wr(8'h30, 32'hFFFF_FFFF, 32'h0000_0060); check_all();
    wr(8'h10, 32'hFFFF_FFFF, 32'h0000_0060); check_all();
    // R7: input falls, pending goes away
    wr(8'h10, 32'h0, 32'h0000_0040); check_all();
    // R3: clear all ones
    wr(8'h38, 32'hFFFF_FFFF, 32'hFFFF_FFFF); check_all();

    for (int k = 0; k < 400; k++) begin
      logic [31:0] s, w;
      s = $urandom();
      w = ($urandom_range(0, 3) == 0) ? 32'h8000_0000 | $urandom() : $urandom();
      wr(ofs[$urandom_range(0, 7)], w, s);
      check_all();
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule